// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a W-bit timer that produces symmetric pulse-width-modulated waveforms on two channels. Its counter climbs from zero to a turning point and then falls back to zero, over and over. The turning point is either the all-ones value of the counter or the active compare value of channel A, chosen by a mode input. Each channel compares the counter with its own active compare value. On a match it drives its registered output to a level set by the channel's two output-mode bits and by the direction of counting at that moment.

Software writes each channel's compare value into a buffer through a plain write port. A buffered value becomes active only on the timer step where the counter turns around at the top. The block raises three sticky flags: one compare-match flag per channel and one flag for reaching the bottom. Each flag is cleared by writing a one to its bit. The counter moves only on cycles where the timer-clock enable input is high, so an outside prescaler sets the speed.

Top module: `pwm_dual_slope`

## Requirements
- R1: While rstN is low, cnt is 0, both outputs are low and all three flags are 0. Counting starts upward after reset.
- R2: cnt changes only on cycles with tickEn high. On each such step it moves by one toward the turning point in use, so it rests exactly one step at the top and one step at zero before reversing.
- R3: With varTop low the top is the all-ones value. With varTop high the top is channel A's active compare value, and a top of 0 keeps cnt at 0.
- R4: Output mode 2 (non-inverting): a step where cnt equals the channel's active compare value drives the output low while counting up and high while counting down.
- R5: Output mode 3 (inverting): the match drives the output high while counting up and low while counting down.
- R6: Output modes 0 and 1: the output is low from the next clock on, whether or not tickEn is high, while the counter and all flags keep running.
- R7: An active compare value of 0 holds the output at its inactive level (low in mode 2, high in mode 3). A value at or above the top holds it at the opposite level. Either level is taken on the first step after the value becomes active, and no pulse appears at zero or at the top.
- R8: A channel's match flag is set on every step where cnt equals that channel's active compare value.
- R9: The bottom flag is set on the step where cnt is 0 while counting down.
- R10: A write to address 0 (channel A) or address 1 (channel B) loads only that channel's buffer. Buffers are copied to the active values on the step where the counter turns at the top. A write in that same cycle takes effect at the next turn.
- R11: A write to address 2 clears the flags selected by ones in the data: bit 0 for the bottom flag, bit 1 for channel A, bit 2 for channel B. Zero bits leave their flag unchanged. A flag being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Timer-clock enable; the counter steps only when high |
| varTop | input | 1 | 0: top is all ones; 1: top is channel A active compare |
| outModeA | input | 2 | Channel A output mode (0/1 off, 2 non-inverting, 3 inverting) |
| outModeB | input | 2 | Channel B output mode |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0: buffer A, 1: buffer B, 2: flag clear |
| wrData | input | W | Write data |
| cnt | output | W | Current counter value |
| pwmA | output | 1 | Channel A waveform |
| pwmB | output | 1 | Channel B waveform |
| flagA | output | 1 | Channel A match flag |
| flagB | output | 1 | Channel B match flag |
| flagOvf | output | 1 | Bottom-reached flag |

## Verification
Two pairs of events can land in the same clock cycle. The first is a flag-clear write and the step that sets the same flag. The second is a compare-buffer write and the turn at the top that copies that buffer. The bench issues clear writes on a fixed cycle stride that does not line up with the counter's period, and writes the buffers at the start of each configuration with the counter at an arbitrary phase. Over the sweep, both kinds of write therefore fall on the very step that sets a flag or loads a buffer. A cycle-stepped model in the bench judges each case: a set on the same step wins over the clear, and a buffer value written on the turn appears only one full period later.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Strobes from the sequencing half to the compare half, valid for one cycle
  typedef struct packed {
    logic tick;      // counter steps this cycle
    logic dirUp;     // direction of the counter before this step
    logic turnTop;   // step that reverses at the top: load compare buffers
    logic atBottom;  // step that reverses at zero
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         varTop,
  input  logic [W-1:0] actA,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top,
  output pwmStrobes_t  strobes
);
  localparam logic [W-1:0] FIXED_TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE       = W'(1);
  localparam logic [W-1:0] ZERO      = '0;

  logic dirUp;
  logic reachedTop;
  logic reachedBottom;

  assign top           = varTop ? actA : FIXED_TOP;
  assign reachedTop    = dirUp && (cnt >= top);
  assign reachedBottom = !dirUp && (cnt == ZERO);

  assign strobes.tick     = tickEn;
  assign strobes.dirUp    = dirUp;
  assign strobes.turnTop  = tickEn && reachedTop;
  assign strobes.atBottom = tickEn && reachedBottom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= ZERO;
      dirUp <= 1'b1;
    end else if (tickEn) begin
      if (reachedTop) begin
        dirUp <= 1'b0;
        cnt   <= (cnt == ZERO) ? ZERO : cnt - ONE;
      end else if (reachedBottom) begin
        dirUp <= 1'b1;
        cnt   <= (top == ZERO) ? ZERO : ONE;
      end else if (dirUp) begin
        cnt <= cnt + ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  pwmStrobes_t  strobes,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic [1:0]   outMode,
  input  logic         wrBuf,
  input  logic [W-1:0] wrData,
  input  logic         clrFlag,
  output logic [W-1:0] actCmp,
  output logic         pin,
  output logic         flag
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] bufCmp;
  logic         hit;
  logic         modeOn;
  logic         inv;

  assign hit    = strobes.tick && (cnt == actCmp);
  assign modeOn = outMode[1];
  assign inv    = outMode[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCmp <= ZERO;
      actCmp <= ZERO;
    end else begin
      if (wrBuf) bufCmp <= wrData;
      if (strobes.turnTop) actCmp <= bufCmp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clrFlag) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pin <= 1'b0;
    end else if (!modeOn) begin
      pin <= 1'b0;
    end else if (strobes.tick) begin
      if (actCmp == ZERO)     pin <= inv;
      else if (actCmp >= top) pin <= !inv;
      else if (hit)           pin <= strobes.dirUp ? inv : !inv;
    end
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  pwmStrobes_t  strobes,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic [1:0]   outModeA,
  input  logic [1:0]   outModeB,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] actA,
  output logic [1:0]   pins,
  output logic [1:0]   flags,
  output logic         flagOvf
);
  localparam int           NCH      = 2;
  localparam logic [1:0]   ADDR_CLR = 2'd2;

  logic [1:0]   modeArr [NCH];
  logic [W-1:0] actArr  [NCH];
  logic         clrSel;

  assign modeArr[0] = outModeA;
  assign modeArr[1] = outModeB;
  assign actA       = actArr[0];
  assign clrSel     = wrEn && (wrAddr == ADDR_CLR);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_channel #(.W(W)) u_channel (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .cnt     (cnt),
      .top     (top),
      .outMode (modeArr[ch]),
      .wrBuf   (wrEn && (wrAddr == 2'(ch))),
      .wrData  (wrData),
      .clrFlag (clrSel && wrData[ch+1]),
      .actCmp  (actArr[ch]),
      .pin     (pins[ch]),
      .flag    (flags[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOvf <= 1'b0;
    end else if (strobes.atBottom) begin
      flagOvf <= 1'b1;
    end else if (clrSel && wrData[0]) begin
      flagOvf <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         varTop,
  input  logic [1:0]   outModeA,
  input  logic [1:0]   outModeB,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cnt,
  output logic         pwmA,
  output logic         pwmB,
  output logic         flagA,
  output logic         flagB,
  output logic         flagOvf
);
  pwmStrobes_t  strobes;
  logic [W-1:0] top;
  logic [W-1:0] actA;
  logic [1:0]   pins;
  logic [1:0]   flags;

  pwm_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .varTop  (varTop),
    .actA    (actA),
    .cnt     (cnt),
    .top     (top),
    .strobes (strobes)
  );

  pwm_datapath #(.W(W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cnt      (cnt),
    .top      (top),
    .outModeA (outModeA),
    .outModeB (outModeB),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .actA     (actA),
    .pins     (pins),
    .flags    (flags),
    .flagOvf  (flagOvf)
  );

  assign pwmA  = pins[0];
  assign pwmB  = pins[1];
  assign flagA = flags[0];
  assign flagB = flags[1];
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         tickEn,
  input logic         varTop,
  input logic [1:0]   outModeA,
  input logic         wrEn,
  input logic [1:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic [W-1:0] cnt,
  input logic [W-1:0] actA,
  input logic         dirUp,
  input logic         pwmA,
  input logic         flagA,
  input logic         flagOvf
);
  localparam logic [W-1:0] ALL1  = {W{1'b1}};
  localparam logic [W-1:0] BELOW = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] ONE   = W'(1);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE) || (cnt == $past(cnt))); // R2

  AST_FIXED_TOP_TURN: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !varTop && (cnt == ALL1) |=> cnt == BELOW); // R3

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !outModeA[1] |=> !pwmA); // R6

  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && (outModeA == 2'd2) && (actA == '0) |=> !pwmA); // R7

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && (cnt == actA) |=> flagA); // R8

  AST_BOTTOM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !dirUp && (cnt == '0) |=> flagOvf); // R9

  AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrAddr == 2'd2) && wrData[1] && !tickEn |=> !flagA); // R11

  AST_CLEAR_OVF: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrAddr == 2'd2) && wrData[0] && !tickEn |=> !flagOvf); // R11
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .varTop   (varTop),
  .outModeA (outModeA),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .cnt      (cnt),
  .actA     (actA),
  .dirUp    (strobes.dirUp),
  .pwmA     (pwmA),
  .flagA    (flagA),
  .flagOvf  (flagOvf)
);

// File: tb/pwm_dual_slope_bench.sv
module pwm_dual_slope_bench;
  localparam int LW = 4;
  localparam logic [LW-1:0] FULL = {LW{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, varTop = 1'b0, wrEn = 1'b0;
  logic [1:0] outModeA = 2'd0, outModeB = 2'd0, wrAddr = 2'd0;
  logic [LW-1:0] wrData = '0;
  logic [LW-1:0] cnt;
  logic pwmA, pwmB, flagA, flagB, flagOvf;

  int checks = 0, errors = 0;
  bit checking = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pwm_dual_slope #(.W(LW)) u_pwm_dual_slope (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .varTop(varTop),
    .outModeA(outModeA), .outModeB(outModeB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cnt(cnt), .pwmA(pwmA), .pwmB(pwmB),
    .flagA(flagA), .flagB(flagB), .flagOvf(flagOvf)
  );

  // Reference state, stepped on each rising edge from the requirements
  logic [LW-1:0] mCnt, mBufA, mBufB, mActA, mActB, mTopQ;
  logic mUp, mPinA, mPinB, mFlA, mFlB, mOvf, mVarQ, mClrQ;
  logic [1:0] mModeAq, mModeBq;

  function automatic logic stepPin(logic old, logic [1:0] mode, logic [LW-1:0] cmp,
                                   logic [LW-1:0] topV, logic [LW-1:0] c, logic up, logic tk);
    if (mode < 2) return 1'b0;
    if (!tk) return old;
    if (cmp == 0) return mode[0];
    if (cmp >= topV) return !mode[0];
    if (c == cmp) return up ? mode[0] : !mode[0];
    return old;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= '0; mUp <= 1'b1; mBufA <= '0; mBufB <= '0; mActA <= '0; mActB <= '0;
      mPinA <= 1'b0; mPinB <= 1'b0; mFlA <= 1'b0; mFlB <= 1'b0; mOvf <= 1'b0;
      mTopQ <= FULL; mVarQ <= 1'b0; mModeAq <= 2'd0; mModeBq <= 2'd0; mClrQ <= 1'b0;
    end else begin
      automatic logic [LW-1:0] t = varTop ? mActA : FULL;
      automatic logic nFlA = mFlA, nFlB = mFlB, nOvf = mOvf;
      automatic logic clr = wrEn && wrAddr == 2'd2;
      if (clr && wrData[0]) nOvf = 1'b0;
      if (clr && wrData[1]) nFlA = 1'b0;
      if (clr && wrData[2]) nFlB = 1'b0;
      if (tickEn && mCnt == mActA) nFlA = 1'b1;
      if (tickEn && mCnt == mActB) nFlB = 1'b1;
      if (tickEn && !mUp && mCnt == 0) nOvf = 1'b1;
      mFlA <= nFlA; mFlB <= nFlB; mOvf <= nOvf;
      mPinA <= stepPin(mPinA, outModeA, mActA, t, mCnt, mUp, tickEn);
      mPinB <= stepPin(mPinB, outModeB, mActB, t, mCnt, mUp, tickEn);
      if (wrEn && wrAddr == 2'd0) mBufA <= wrData;
      if (wrEn && wrAddr == 2'd1) mBufB <= wrData;
      if (tickEn) begin
        if (mUp && mCnt >= t) begin
          mActA <= mBufA; mActB <= mBufB; mUp <= 1'b0;
          mCnt <= (mCnt == 0) ? '0 : mCnt - 1'b1;
        end else if (!mUp && mCnt == 0) begin
          mUp <= 1'b1; mCnt <= (t == 0) ? '0 : LW'(1);
        end else mCnt <= mUp ? mCnt + 1'b1 : mCnt - 1'b1;
      end
      mTopQ <= t; mVarQ <= varTop; mModeAq <= outModeA; mModeBq <= outModeB; mClrQ <= clr;
    end
  end

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string pinTag(logic [1:0] mode, logic [LW-1:0] act, logic [LW-1:0] buff);
    if (mode < 2) return "R6";
    if (act != buff) return "R10";
    if (act == 0 || act >= mTopQ) return "R7";
    return (mode == 2) ? "R4" : "R5";
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      check(cnt, mCnt, mVarQ ? "R3" : "R2", "counter");
      check(pwmA, mPinA, pinTag(mModeAq, mActA, mBufA), "output A");
      check(pwmB, mPinB, pinTag(mModeBq, mActB, mBufB), "output B");
      check(flagA, mFlA, mClrQ ? "R11" : "R8", "flag A");
      check(flagB, mFlB, mClrQ ? "R11" : "R8", "flag B");
      check(flagOvf, mOvf, mClrQ ? "R11" : "R9", "bottom flag");
    end
  end

  task automatic runCfg(int a, int b);
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = LW'(a); tickEn = 1'b1;
    @(negedge clk); wrAddr = 2'd1; wrData = LW'(b);
    outModeA = 2'((a + b) % 4); outModeB = 2'(b % 4); varTop = (a % 3 == 0);
    for (int cyc = 0; cyc < 120; cyc++) begin
      @(negedge clk);
      case ((a + b) % 3)
        0: tickEn = 1'b1;
        1: tickEn = cyc[0];
        default: tickEn = (cyc % 3 != 1);
      endcase
      wrEn = (cyc % 11 == 5);
      wrAddr = 2'd2;
      wrData = LW'(cyc / 11);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cnt, 0, "R1", "reset counter");
    check(pwmA, 0, "R1", "reset output A");
    check(pwmB, 0, "R1", "reset output B");
    check({flagOvf, flagB, flagA}, 0, "R1", "reset flags");
    rstN = 1'b1;
    @(negedge clk);
    checking = 1'b1;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        runCfg(a, b);
    @(negedge clk);
    checking = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule